// File: doc/BRIEF.md
# Transmitter Error-State Change Interrupt Filter

This block sits beside the error counters of a CAN controller and watches the transmitter's fault confinement state. It turns the transmit error counter and a bus-off indication into a two-bit state, reports that state to software, and raises a pending status-change flag when the state moves in a way that software has asked to hear about. A two-bit sensitivity code picks which moves count: none, only moves into or out of bus-off, moves that cross the error boundary, or every move.

While a status-change event is pending, the reported state stays frozen at the value that caused it. Software reads that value, then clears the flag by writing 1. On the clock after the clear, the reported state catches up with the live state. If that catch-up is itself a qualifying move, the flag is raised again. The sensitivity code and a global enable bit live in a small configuration register. This register is forced to its reset value, and ignores writes, while the controller's initialization handshake is active. The interrupt request is the pending flag gated by the global enable.

Top module: `txerr_state_irq`

## Requirements
- R1: The live state is 3 (bus-off) when `bus_off` is 1, whatever the counter. Otherwise it is 2 (error) for a counter of 128 or more, 1 (warning) for 96 to 127, and 0 (ok) below 96.
- R2: With sensitivity code 00 (bits [1:0] of `cfg_wdata`), no state change sets the pending flag.
- R3: With code 01, only a change whose old or new state is bus-off (3), but not both, sets the pending flag.
- R4: With code 10, only a change where bit 1 of the old state differs from bit 1 of the new state sets the pending flag. This is entering or leaving the error/bus-off group.
- R5: With code 11, every change of state sets the pending flag.
- R6: While no event is pending, `tx_state` takes the live state one clock after the inputs present it, whatever the sensitivity code.
- R7: While the pending flag is 1, `tx_state` holds its value.
- R8: On the clock after the pending flag returns to 0, `tx_state` takes the live state. A qualifying difference from the frozen value sets the flag again on that same edge.
- R9: A cycle with `clr_wr`=1 and `clr_val`=1 clears the pending flag. With `clr_val`=0 the flag is left unchanged.
- R10: If a qualifying change and a clear fall on the same edge, the flag ends up set.
- R11: `irq` equals the pending flag ANDed with the global enable (bit 2 of `cfg_wdata`).
- R12: While `init_req` and `init_ack` are both 1, the configuration register is held at 0 (code 00, enable 0) and ignores writes.
- R13: A configuration write is taken only while `init_req` and `init_ack` are both 0. With only one of them at 1, a write is ignored and the stored value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_cnt | input | 8 | Transmit error counter value |
| bus_off | input | 1 | Transmitter is in bus-off |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 3 | [1:0] sensitivity code, [2] global enable |
| clr_wr | input | 1 | Pending flag write strobe |
| clr_val | input | 1 | Value written to the pending flag (1 clears) |
| tx_state | output | 2 | Reported transmitter state |
| chg_pend | output | 1 | Pending status-change flag |
| irq | output | 1 | Status-change interrupt request |

## Verification
The assertions assume that the counter and bus-off inputs are stable between clock edges. They also assume that reset is held long enough for the configuration and flag registers to settle before any property is armed. The tracking check rebuilds the live state from the port values of the previous edge. The bench changes every input on the falling edge only and holds reset for several cycles. It drives each of the sixteen old/new state pairs under each sensitivity code from a settled, non-pending starting point, so that each change is seen against a known frozen value.

// File: rtl/txerr_pkg.sv
// Shared types for the transmitter error-state interrupt filter.
// Assumes the two-bit state ordering ok < warning < error < bus-off.
package txerr_pkg;

    typedef enum logic [1:0] {
        TXS_OK   = 2'b00,
        TXS_WARN = 2'b01,
        TXS_ERR  = 2'b10,
        TXS_BOFF = 2'b11
    } txs_e;

    typedef enum logic [1:0] {
        SENS_NONE = 2'b00,
        SENS_BOFF = 2'b01,
        SENS_ERR  = 2'b10,
        SENS_ALL  = 2'b11
    } sens_e;

    typedef struct packed {
        logic  en;
        sens_e sens;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/txerr_classify.sv
// Maps the transmit error counter and the bus-off indication onto a
// two-bit state. Purely combinational. Assumes WARN_LVL < ERR_LVL and
// that both levels fit in CNT_W bits.
module txerr_classify
    import txerr_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int ERR_LVL  = 128
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             boff,
    output txs_e             state
);
    localparam logic [CNT_W-1:0] WARN_T = CNT_W'(WARN_LVL);
    localparam logic [CNT_W-1:0] ERR_T  = CNT_W'(ERR_LVL);

    // Priority: bus-off, then the error band, then the warning band.
    always_comb begin
        if (boff)
            state = TXS_BOFF;
        else if (cnt >= ERR_T)
            state = TXS_ERR;
        else if (cnt >= WARN_T)
            state = TXS_WARN;
        else
            state = TXS_OK;
    end
endmodule

// File: rtl/txerr_sens_filter.sv
// Decides whether a move from old_s to new_s qualifies under the
// programmed sensitivity code. Combinational. Assumes a caller that
// only asks about a real change when it wants one reported.
module txerr_sens_filter
    import txerr_pkg::*;
(
    input  sens_e sens,
    input  txs_e  old_s,
    input  txs_e  new_s,
    output logic  qualify
);
    logic moved;
    logic boff_edge;
    logic err_edge;

    // Classify the move along the three axes the codes select from.
    always_comb begin
        moved     = (old_s != new_s);
        boff_edge = (old_s == TXS_BOFF) != (new_s == TXS_BOFF);
        err_edge  = old_s[1] != new_s[1];
    end

    // Pick the axis named by the sensitivity code.
    always_comb begin
        unique case (sens)
            SENS_NONE: qualify = 1'b0;
            SENS_BOFF: qualify = boff_edge;
            SENS_ERR:  qualify = err_edge;
            SENS_ALL:  qualify = moved;
            default:   qualify = 1'b0;
        endcase
    end
endmodule

// File: rtl/txerr_cfg_reg.sv
// Sensitivity/enable register. It is held at reset while initialization
// is fully active, and it takes writes only when the handshake is fully
// idle. Assumes synchronous active-low reset.
module txerr_cfg_reg
    import txerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);
    logic in_init;
    logic wr_ok;

    // Decode the handshake into hold and write-enable conditions.
    always_comb begin
        in_init = init_req && init_ack;
        wr_ok   = wr && !init_req && !init_ack;
    end

    // Register update: reset, init hold, or accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || in_init)
            cfg_q <= '0;
        else if (wr_ok)
            cfg_q <= cfg_t'(wdata);
    end
endmodule

// File: rtl/txerr_flag_ctrl.sv
// Holds the reported state and the pending flag. The reported state
// follows the live state only while nothing is pending, and a change is
// judged against the reported (possibly frozen) value. A set on the
// same edge as a clear wins.
module txerr_flag_ctrl
    import txerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  txs_e live_s,
    input  logic qualify,
    input  logic clr,
    output txs_e rpt_s,
    output logic pend
);
    logic set_ev;

    // A set is only possible while reporting is not frozen.
    always_comb set_ev = !pend && qualify;

    // Reported state: track live value unless an event is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rpt_s <= TXS_OK;
        else if (!pend)
            rpt_s <= live_s;
    end

    // Pending flag: set has priority over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (set_ev)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end
endmodule

// File: rtl/txerr_state_irq.sv
// Top of the transmitter error-state change interrupt filter. It ties
// together the classifier, the sensitivity filter, the configuration
// register and the flag control. Assumes the counter and bus-off inputs
// are synchronous to clk.
module txerr_state_irq
    import txerr_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int ERR_LVL  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic             bus_off,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             clr_wr,
    input  logic             clr_val,
    output logic [1:0]       tx_state,
    output logic             chg_pend,
    output logic             irq
);
    txs_e live_s;
    txs_e rpt_s;
    cfg_t cfg_q;
    logic qualify;
    logic clr;
    logic pend;

    txerr_classify #(
        .CNT_W   (CNT_W),
        .WARN_LVL(WARN_LVL),
        .ERR_LVL (ERR_LVL)
    ) classify_i (
        .cnt  (tx_err_cnt),
        .boff (bus_off),
        .state(live_s)
    );

    txerr_cfg_reg cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_req(init_req),
        .init_ack(init_ack),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    txerr_sens_filter filt_i (
        .sens   (cfg_q.sens),
        .old_s  (rpt_s),
        .new_s  (live_s),
        .qualify(qualify)
    );

    // Write-one-to-clear decode of the flag write port.
    always_comb clr = clr_wr && clr_val;

    txerr_flag_ctrl flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .live_s (live_s),
        .qualify(qualify),
        .clr    (clr),
        .rpt_s  (rpt_s),
        .pend   (pend)
    );

    // Output drive: reported state, flag and gated request.
    always_comb begin
        tx_state = rpt_s;
        chg_pend = pend;
        irq      = pend && cfg_q.en;
    end
endmodule

// File: rtl/txerr_state_irq_chk.sv
// Property checker for txerr_state_irq. It rebuilds the live state from
// the ports and watches the reported state, the flag and the request.
module txerr_state_irq_chk #(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int ERR_LVL  = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tx_err_cnt,
    input logic             bus_off,
    input logic             init_req,
    input logic             init_ack,
    input logic             clr_wr,
    input logic             clr_val,
    input logic [1:0]       tx_state,
    input logic             chg_pend,
    input logic             irq,
    input logic [1:0]       sens
);
    logic [1:0] cls_q;

    // Independent registered classification of the port inputs (R1).
    always_ff @(posedge clk) begin
        if (bus_off)
            cls_q <= 2'd3;
        else if (int'(tx_err_cnt) >= ERR_LVL)
            cls_q <= 2'd2;
        else if (int'(tx_err_cnt) >= WARN_LVL)
            cls_q <= 2'd1;
        else
            cls_q <= 2'd0;
    end

    assert_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(chg_pend)) |-> (tx_state == cls_q));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(chg_pend)) |-> $stable(tx_state));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sens) == 2'b00 && !$past(chg_pend)) |-> !chg_pend);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(chg_pend) && !chg_pend) |-> $past(clr_wr && clr_val));

    assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> chg_pend);

    assert_init_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(init_req && init_ack)) |-> !irq);
endmodule

bind txerr_state_irq txerr_state_irq_chk #(
    .CNT_W   (CNT_W),
    .WARN_LVL(WARN_LVL),
    .ERR_LVL (ERR_LVL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_err_cnt(tx_err_cnt),
    .bus_off   (bus_off),
    .init_req  (init_req),
    .init_ack  (init_ack),
    .clr_wr    (clr_wr),
    .clr_val   (clr_val),
    .tx_state  (tx_state),
    .chg_pend  (chg_pend),
    .irq       (irq),
    .sens      (cfg_q.sens)
);

// File: tb/txerr_state_irq_tb.sv
// Sweep bench for txerr_state_irq: all codes against all state pairs,
// plus the counter boundaries, freeze/catch-up, clear and init handling.
module txerr_state_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_err_cnt = 8'd0;
    logic       bus_off = 1'b0;
    logic       init_req = 1'b0;
    logic       init_ack = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = 3'd0;
    logic       clr_wr = 1'b0;
    logic       clr_val = 1'b0;
    logic [1:0] tx_state;
    logic       chg_pend;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    txerr_state_irq dut_i (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .bus_off(bus_off),
        .init_req(init_req), .init_ack(init_ack), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .clr_wr(clr_wr), .clr_val(clr_val),
        .tx_state(tx_state), .chg_pend(chg_pend), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_state(input int cnt, input bit bo);
        if (bo) return 3;
        if (cnt >= 128) return 2;
        if (cnt >= 96) return 1;
        return 0;
    endfunction

    function automatic bit exp_qual(input int o, input int n, input int c);
        case (c)
            0: return 1'b0;
            1: return (o == 3) != (n == 3);
            2: return (o / 2) != (n / 2);
            default: return o != n;
        endcase
    endfunction

    // Drive a state: pick a counter value in the band, varied by salt.
    task automatic drive_state(input int s, input int salt);
        bus_off = (s == 3);
        case (s)
            0: tx_err_cnt = 8'((salt * 7) % 96);
            1: tx_err_cnt = 8'(96 + (salt * 5) % 32);
            2: tx_err_cnt = 8'(128 + (salt * 11) % 128);
            default: tx_err_cnt = 8'((salt * 37) % 256);
        endcase
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input int v);
        cfg_wr = 1'b1; cfg_wdata = 3'(v);
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic clear_flag(input bit v);
        clr_wr = 1'b1; clr_val = v;
        tick();
        clr_wr = 1'b0; clr_val = 1'b0;
    endtask

    // Hold a state and clear until settled with nothing pending.
    task automatic settle(input int s, input int salt);
        drive_state(s, salt);
        for (int k = 0; k < 3; k++) begin
            tick();
            clear_flag(1'b1);
        end
        tick();
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        repeat (4) tick();
        // Reset state (R6, R11).
        check("R6 reset state", tx_state, 0);
        check("R9 reset flag", chg_pend, 0);
        check("R11 reset irq", irq, 0);
        rst_n = 1'b1;
        tick();

        // R1: boundaries, observed with code 00 so nothing freezes.
        begin
            int cnts[6] = '{0, 95, 96, 127, 128, 255};
            foreach (cnts[i]) begin
                tx_err_cnt = 8'(cnts[i]); bus_off = 1'b0;
                tick();
                check("R1 counter band", tx_state, exp_state(cnts[i], 1'b0));
                check("R2 no flag at code 00", chg_pend, 0);
            end
            tx_err_cnt = 8'd0; bus_off = 1'b1;
            tick();
            check("R1 bus-off priority", tx_state, 3);
            bus_off = 1'b0;
            tick();
        end

        // R2-R5, R6, R11: every code against every old/new pair.
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 4; o++) begin
                for (int n = 0; n < 4; n++) begin
                    int en = (o + n + c) % 2;
                    write_cfg(en * 4 + c);
                    settle(o, o + c);
                    check("R6 settled old state", tx_state, o);
                    drive_state(n, n + 3 * c + o);
                    tick();
                    check($sformatf("R%0d code %0d flag", c + 2, c) == "" ? "" :
                          (c == 0 ? "R2 code 00 flag" : c == 1 ? "R3 code 01 flag" :
                           c == 2 ? "R4 code 10 flag" : "R5 code 11 flag"),
                          chg_pend, int'(exp_qual(o, n, c)));
                    check("R6 new state shown", tx_state, n);
                    check("R11 irq gating", irq, int'(exp_qual(o, n, c)) & en);
                end
            end
        end

        // R7, R8: freeze while pending, then catch up on the next clock.
        write_cfg(3'b111);
        settle(0, 1);
        drive_state(2, 1);
        tick();
        check("R5 flag on move", chg_pend, 1);
        drive_state(1, 2);
        tick();
        drive_state(3, 2);
        tick();
        check("R7 frozen state", tx_state, 2);
        clear_flag(1'b1);
        check("R8 flag cleared", chg_pend, 0);
        check("R8 still old on clear edge", tx_state, 2);
        tick();
        check("R8 catches up", tx_state, 3);
        check("R8 re-raised by catch-up", chg_pend, 1);

        // R9: writing 0 leaves the flag set.
        clear_flag(1'b0);
        check("R9 write 0 ignored", chg_pend, 1);
        clear_flag(1'b1);
        tick();
        check("R9 write 1 clears", chg_pend, 0);

        // R10: change and clear on the same edge.
        settle(0, 4);
        drive_state(1, 4);
        clr_wr = 1'b1; clr_val = 1'b1;
        tick();
        clr_wr = 1'b0; clr_val = 1'b0;
        check("R10 set wins", chg_pend, 1);
        check("R11 irq with enable", irq, 1);

        // R12: full init forces config to zero and blocks writes.
        init_req = 1'b1; init_ack = 1'b1;
        tick();
        check("R12 irq masked in init", irq, 0);
        write_cfg(3'b111);
        init_req = 1'b0; init_ack = 1'b0;
        tick();
        clear_flag(1'b1);
        settle(0, 5);
        drive_state(3, 5);
        tick();
        check("R12 config held at zero", chg_pend, 0);

        // R13: half handshake ignores writes; idle accepts them.
        init_req = 1'b1;
        write_cfg(3'b111);
        init_req = 1'b0;
        settle(0, 6);
        drive_state(3, 6);
        tick();
        check("R13 write ignored with req only", chg_pend, 0);
        init_ack = 1'b1;
        write_cfg(3'b111);
        init_ack = 1'b0;
        settle(0, 7);
        drive_state(3, 7);
        tick();
        check("R13 write ignored with ack only", chg_pend, 0);
        write_cfg(3'b111);
        settle(0, 8);
        drive_state(3, 8);
        tick();
        check("R13 write taken when idle", chg_pend, 1);
        check("R13 irq after accepted write", irq, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule